// File: doc/BRIEF.md
# Converter Fault Supervisor with Auto-Restart

This block decides, every clock cycle, whether the gate driver of an offline switching converter may run. It never sees voltages or temperatures directly; comparators elsewhere reduce each condition to a flag. From these flags the supervisor builds a hysteretic supply-enable, qualifies each fault by its own rule (a time debounce for supply over-voltage, a per-switching-cycle sample for the knee over-voltage, a consecutive-cycle run for a shorted output diode, a two-threshold hold for temperature) and forces the gate off while any fault stands.

Faults recover in two ways. Supply over-voltage and over-temperature release the gate on their own once the condition is gone. Knee over-voltage and the diode-short run latch the block off: the supply-enable is dropped and the gate only returns after a fresh start, which means the supply must first fall below the turn-off level and then rise above the turn-on level. If the fault is still there after that start, it trips again. A 3-bit code reports the highest-priority reason the gate is off.

Top module: `conv_fault_sup`

## Requirements
- R1: While rst_n is low at a clock edge, gate_enable is 0 after that edge and fault_code is 5 (supply below start); the supply-enable starts armed.
- R2: The supply-enable is hysteretic: with the enable armed and no fault, sup_above_on sampled high turns gate_enable on after that edge; with neither level flag high the state holds; sup_below_off sampled high turns it off after that edge and re-arms it.
- R3: sup_ovp_flag turns gate_enable off (code 2) only after it has been sampled high on OVP_DEBOUNCE consecutive edges (default 1000, 10 us at 100 MHz); one fewer sample has no effect, and one edge with the flag low restores the gate without a fresh start.
- R4: While gate_enable is high, an edge with cycle_strobe and knee_ovp_flag both high latches an output over-voltage fault (code 3) and gate_enable is 0 after that edge; knee_ovp_flag without cycle_strobe is ignored.
- R5: While gate_enable is high, SHORT_RUN (default 7) consecutive strobed cycles with cs_short_flag high latch a diode-short fault (code 4) after the last of them; a strobed cycle with the flag low restarts the count.
- R6: A latched fault (code 3 or 4) also drops and disarms the supply-enable; sup_above_on alone does not restart, sup_below_off re-arms it, and the next sup_above_on clears the latch and turns gate_enable on.
- R7: temp_hot_flag sampled high forces gate_enable off (code 1) after that edge; the hold stays with neither temperature flag high and ends one edge after temp_cool_flag is sampled high.
- R8: During a temperature hold the supply-enable still follows the level flags, so if sup_below_off was seen during the hold, gate_enable stays 0 (code 5) after the hold ends until sup_above_on is seen (hiccup restart).
- R9: fault_code reports the highest active reason in the order 1 over-temperature, 2 supply over-voltage, 3 output over-voltage, 4 diode short, 5 supply-enable off; 0 means running.
- R10: gate_enable is 1 exactly when fault_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_above_on | input | 1 | Supply above turn-on level |
| sup_below_off | input | 1 | Supply below turn-off level |
| sup_ovp_flag | input | 1 | Supply over-voltage comparator |
| knee_ovp_flag | input | 1 | Output over-voltage from the knee sample |
| cs_short_flag | input | 1 | Current-sense peak above diode-short level |
| temp_hot_flag | input | 1 | Die temperature above shutdown level |
| temp_cool_flag | input | 1 | Die temperature below release level |
| cycle_strobe | input | 1 | One-cycle pulse per switching period |
| gate_enable | output | 1 | Gate driver may switch |
| fault_code | output | 3 | Highest-priority off reason, 0 when running |

## Verification
Every result is held in a register and both outputs decode only those registers, so a flag sampled at one rising edge shows its effect after that same edge: one cycle for the level, temperature, knee and diode-short rules, and on the OVP_DEBOUNCE-th consecutive high sample for supply over-voltage. The driver changes inputs on the falling edge, waits for the next rising edge and then queues the expected gate and code; the monitor compares on the following falling edge, half a cycle after the registers settle. Debounce and run-length boundaries are checked one sample short of the limit and exactly at it.

// File: rtl/fsup_pkg.sv
// Package: shared fault code encoding for the converter fault supervisor.
// Assumes: codes are ordered so that a lower non-zero value wins.
package fsup_pkg;
    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_OTP  = 3'd1,
        FC_SOVP = 3'd2,
        FC_OOVP = 3'd3,
        FC_DSC  = 3'd4,
        FC_UVLO = 3'd5
    } fault_code_e;
endpackage

// File: rtl/fsup_uvlo.sv
// Module: hysteretic supply-enable with arming.
// Sets run on the turn-on flag only when armed; the turn-off flag clears run
// and re-arms. A trip pulse clears run and disarms, forcing a fresh start.
// Assumes: start is used by the parent to clear latched faults.
module fsup_uvlo (
    input  logic clk,
    input  logic rst_n,
    input  logic above_on,
    input  logic below_off,
    input  logic trip,
    output logic run,
    output logic start
);
    logic armed;

    // start: run is about to rise this edge
    always_comb begin
        start = ~run & armed & above_on & ~below_off & ~trip;
    end

    // run/armed state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            armed <= 1'b1;
        end else if (trip) begin
            run   <= 1'b0;
            armed <= 1'b0;
        end else if (below_off) begin
            run   <= 1'b0;
            armed <= 1'b1;
        end else if (start) begin
            run   <= 1'b1;
        end
    end
endmodule

// File: rtl/fsup_debounce.sv
// Module: time debounce; qual rises after DEPTH consecutive high samples of
// raw and falls on the first low sample.
// Assumes: DEPTH >= 2.
module fsup_debounce #(
    parameter int DEPTH = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic qual
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] cnt;

    // count consecutive high samples, qualify at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (!raw) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (cnt == LAST) begin
            qual <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsup_run_count.sv
// Module: consecutive strobed-cycle counter. hit fires on the strobe that
// completes RUN_LEN flagged cycles in a row while enabled.
// Assumes: RUN_LEN >= 2; a strobe with flag low or enable low clears the run.
module fsup_run_count #(
    parameter int RUN_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic flag,
    output logic hit
);
    localparam int CW = $clog2(RUN_LEN);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt;

    // hit on the completing strobe
    always_comb begin
        hit = enable & strobe & flag & (cnt == LAST);
    end

    // run length tracking
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (strobe) begin
            if (!flag || hit) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsup_thermal.sv
// Module: temperature hold with two-threshold hysteresis.
// Assumes: hot wins if both flags are high in the same cycle.
module fsup_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    output logic hold
);
    // set on hot, release on cool
    always_ff @(posedge clk) begin
        if (!rst_n)    hold <= 1'b0;
        else if (hot)  hold <= 1'b1;
        else if (cool) hold <= 1'b0;
    end
endmodule

// File: rtl/conv_fault_sup.sv
// Module: converter fault supervisor top. Combines the supply-enable,
// supply over-voltage debounce, knee over-voltage and diode-short latches and
// temperature hold into gate_enable and a priority fault code.
// Assumes: all flags are synchronous to clk; cycle_strobe is one clock wide.
module conv_fault_sup #(
    parameter int OVP_DEBOUNCE = 1000,
    parameter int SHORT_RUN    = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_above_on,
    input  logic       sup_below_off,
    input  logic       sup_ovp_flag,
    input  logic       knee_ovp_flag,
    input  logic       cs_short_flag,
    input  logic       temp_hot_flag,
    input  logic       temp_cool_flag,
    input  logic       cycle_strobe,
    output logic       gate_enable,
    output logic [2:0] fault_code
);
    import fsup_pkg::*;

    logic run, start, sovp_act, ot_hold;
    logic dsc_hit, oovp_hit, trip;
    logic dsc_lat, oovp_lat;
    fault_code_e code_e;

    fsup_uvlo u_uvlo (
        .clk(clk), .rst_n(rst_n), .above_on(sup_above_on),
        .below_off(sup_below_off), .trip(trip), .run(run), .start(start)
    );

    fsup_debounce #(.DEPTH(OVP_DEBOUNCE)) u_sovp (
        .clk(clk), .rst_n(rst_n), .raw(sup_ovp_flag), .qual(sovp_act)
    );

    fsup_run_count #(.RUN_LEN(SHORT_RUN)) u_dsc (
        .clk(clk), .rst_n(rst_n), .enable(gate_enable),
        .strobe(cycle_strobe), .flag(cs_short_flag), .hit(dsc_hit)
    );

    fsup_thermal u_temp (
        .clk(clk), .rst_n(rst_n), .hot(temp_hot_flag),
        .cool(temp_cool_flag), .hold(ot_hold)
    );

    // gate permission and latched-fault trip events
    always_comb begin
        gate_enable = run & ~ot_hold & ~sovp_act & ~dsc_lat & ~oovp_lat;
        oovp_hit    = gate_enable & cycle_strobe & knee_ovp_flag;
        trip        = dsc_hit | oovp_hit;
    end

    // latched faults: set on trip, cleared by a fresh start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_lat  <= 1'b0;
            oovp_lat <= 1'b0;
        end else if (start) begin
            dsc_lat  <= 1'b0;
            oovp_lat <= 1'b0;
        end else begin
            if (dsc_hit)  dsc_lat  <= 1'b1;
            if (oovp_hit) oovp_lat <= 1'b1;
        end
    end

    // priority encoder of the off reason
    always_comb begin
        if (ot_hold)       code_e = FC_OTP;
        else if (sovp_act) code_e = FC_SOVP;
        else if (oovp_lat) code_e = FC_OOVP;
        else if (dsc_lat)  code_e = FC_DSC;
        else if (!run)     code_e = FC_UVLO;
        else               code_e = FC_NONE;
        fault_code = code_e;
    end
endmodule

// File: rtl/fsup_checker.sv
// Module: property checker for conv_fault_sup, bound to every instance.
// Assumes: sees only the top-level ports.
module fsup_checker #(
    parameter int SHORT_RUN = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_below_off,
    input logic       sup_ovp_flag,
    input logic       knee_ovp_flag,
    input logic       cs_short_flag,
    input logic       temp_hot_flag,
    input logic       cycle_strobe,
    input logic       gate_enable,
    input logic [2:0] fault_code
);
    localparam int CW = $clog2(SHORT_RUN) + 1;
    logic [CW-1:0] seen;

    // independent tally of consecutive flagged strobes while running
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_enable)            seen <= '0;
        else if (cycle_strobe && cs_short_flag) seen <= seen + 1'b1;
        else if (cycle_strobe)                 seen <= '0;
    end

    AST_RESET_OFF: assert property (@(posedge clk) !rst_n |=> !gate_enable && fault_code == 3'd5); // R1
    AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n) sup_below_off |=> !gate_enable); // R2
    AST_SOVP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !sup_ovp_flag |=> fault_code != 3'd2); // R3
    AST_KNEE_TRIP: assert property (@(posedge clk) disable iff (!rst_n) gate_enable && cycle_strobe && knee_ovp_flag |=> !gate_enable); // R4
    AST_SHORT_TRIP: assert property (@(posedge clk) disable iff (!rst_n) gate_enable && cycle_strobe && cs_short_flag && seen == CW'(SHORT_RUN - 1) |=> !gate_enable); // R5
    AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n) temp_hot_flag |=> !gate_enable && fault_code == 3'd1); // R7
    AST_GATE_CODE: assert property (@(posedge clk) disable iff (!rst_n) gate_enable == (fault_code == 3'd0)); // R10
endmodule

bind conv_fault_sup fsup_checker #(.SHORT_RUN(SHORT_RUN)) u_chk (
    .clk(clk), .rst_n(rst_n), .sup_below_off(sup_below_off),
    .sup_ovp_flag(sup_ovp_flag), .knee_ovp_flag(knee_ovp_flag),
    .cs_short_flag(cs_short_flag), .temp_hot_flag(temp_hot_flag),
    .cycle_strobe(cycle_strobe), .gate_enable(gate_enable),
    .fault_code(fault_code)
);

// File: tb/sim_conv_fault_sup.sv
// Bench: scoreboard for conv_fault_sup. Driver pushes expectations after each
// rising edge; monitor pops and compares on the falling edge.
module sim_conv_fault_sup;
    localparam int DEB = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_on = 0, below_off = 0, sovp = 0, kovp = 0, csf = 0;
    logic hot = 0, cool = 0, strobe = 0;
    logic gate;
    logic [2:0] code;

    typedef struct {
        logic       g;
        logic [2:0] c;
        string      tag;
    } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    conv_fault_sup u0 (
        .clk(clk), .rst_n(rst_n), .sup_above_on(above_on),
        .sup_below_off(below_off), .sup_ovp_flag(sovp),
        .knee_ovp_flag(kovp), .cs_short_flag(csf), .temp_hot_flag(hot),
        .temp_cool_flag(cool), .cycle_strobe(strobe),
        .gate_enable(gate), .fault_code(code)
    );

    // monitor: compare queued expectations half a cycle after the edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (gate !== e.g || code !== e.c) begin
                fails++;
                $display("FAIL %s: gate=%0d code=%0d expected gate=%0d code=%0d",
                         e.tag, gate, code, e.g, e.c);
            end
        end
    end

    // one clock with current inputs, optionally queue an expectation
    task automatic tick(input bit chk, input logic g, input logic [2:0] c, input string tag);
        @(posedge clk);
        if (chk) q.push_back('{g: g, c: c, tag: tag});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, "");
    endtask

    task automatic fresh_start();
        below_off = 1; tick(0, 0, 0, "");
        below_off = 0; above_on = 1; tick(1, 1, 3'd0, "R6 fresh start");
        above_on = 0;
    endtask

    initial begin
        @(negedge clk);
        rst_n = 0;
        tick(0, 0, 0, "");
        tick(1, 0, 3'd5, "R1 reset state");
        rst_n = 1;
        tick(1, 0, 3'd5, "R2 no start without turn-on flag");
        above_on = 1; tick(1, 1, 3'd0, "R2 start on turn-on flag");
        above_on = 0; tick(1, 1, 3'd0, "R2 hold between thresholds");
        below_off = 1; tick(1, 0, 3'd5, "R2 stop on turn-off flag");
        below_off = 0; tick(1, 0, 3'd5, "R2 stays off between thresholds");
        above_on = 1; tick(1, 1, 3'd0, "R2 restart after re-arm");
        above_on = 0;

        // R3 debounce boundary
        sovp = 1;
        idle(DEB - 2);
        tick(1, 1, 3'd0, "R3 one sample short of debounce");
        tick(1, 0, 3'd2, "R3 trip at debounce limit");
        sovp = 0; tick(1, 1, 3'd0, "R3 auto resume");

        // R4 knee over-voltage
        kovp = 1; tick(1, 1, 3'd0, "R4 knee flag without strobe ignored");
        strobe = 1; tick(1, 0, 3'd3, "R4 knee trip latched");
        kovp = 0; strobe = 0; tick(1, 0, 3'd3, "R4 latch holds");
        above_on = 1; tick(1, 0, 3'd3, "R6 no restart while disarmed");
        above_on = 0;
        below_off = 1; tick(1, 0, 3'd3, "R9 latch code over supply-off");
        below_off = 0; above_on = 1; tick(1, 1, 3'd0, "R6 restart after re-arm");
        above_on = 0;

        // R5 diode-short run length
        csf = 1; strobe = 1;
        idle(5);
        tick(1, 1, 3'd0, "R5 six flagged cycles");
        csf = 0; tick(1, 1, 3'd0, "R5 clean cycle restarts count");
        csf = 1;
        idle(5);
        tick(1, 1, 3'd0, "R5 six again after restart");
        strobe = 0; tick(1, 1, 3'd0, "R5 no strobe no count");
        strobe = 1; tick(1, 0, 3'd4, "R5 seventh consecutive trips");
        csf = 0; strobe = 0;
        fresh_start();

        // R7 temperature hold
        hot = 1; tick(1, 0, 3'd1, "R7 hot shuts gate");
        hot = 0; tick(1, 0, 3'd1, "R7 hold between thresholds");
        cool = 1; tick(1, 1, 3'd0, "R7 release on cool");
        cool = 0;

        // R8 hiccup during hold
        hot = 1; tick(1, 0, 3'd1, "R8 hold entered");
        hot = 0; below_off = 1; tick(1, 0, 3'd1, "R9 temperature over supply-off");
        below_off = 0; cool = 1; tick(1, 0, 3'd5, "R8 needs restart after hold");
        cool = 0; above_on = 1; tick(1, 1, 3'd0, "R8 hiccup restart");
        above_on = 0;

        // R9 priority between temperature and supply over-voltage
        sovp = 1;
        idle(DEB - 1);
        tick(1, 0, 3'd2, "R9 supply over-voltage code");
        hot = 1; tick(1, 0, 3'd1, "R9 temperature wins");
        hot = 0; cool = 1; tick(1, 0, 3'd2, "R9 supply over-voltage remains");
        sovp = 0; cool = 0; tick(1, 1, 3'd0, "R10 gate with code zero");

        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule